// File: doc/BRIEF.md
# Mailbox Slot Bank

This block is a bank of mailbox slots that two processor cores share to pass fixed-length messages. Each slot has one mode word and a payload of eight 32-bit data words. The slots sit at a fixed stride of 0x40 bytes. Both sides reach the bank over a simple synchronous register port. A request is held for one cycle. The port answers with `ready` and, for a read, with the data in the following cycle.

The mode word holds two fields. The first is a one-hot lifecycle state: idle, transmit, receive or acknowledge. The second is a bit that chooses how an acknowledge is handled. Each slot has its own acknowledge input from the remote side. When the slot is busy, a pulse on that input moves the state on:

- In automatic mode the state goes straight back to idle, so a polling sender sees completion.
- In interrupt mode the state parks in acknowledge until software writes idle.

Every slot's state field and mode bit are also driven out continuously, for the logic around the bank.

Top module: `mbx_slot_bank`

## Requirements
- R1: After reset, the following hold:
  - every slot state is idle (0x1) and every mode bit is 0;
  - all data words read zero;
  - `ready` and `rd_data` are 0.
- R2: Slot m occupies byte offsets 0x40*m to 0x40*m+0x3F. Its mode word is at offset 0x0. Data word k (k = 0..7) is at offset 0x4+4k. A data word that is written reads back unchanged. Address bits 1:0 are ignored.
- R3: `ready` is high in exactly the cycle after a cycle with `sel` high. In that cycle `rd_data` carries the read result. `rd_data` is 0 whenever the access was a write or there was no access.
- R4: The mode word layout is as follows:
  - bits 7:4 hold the state, one-hot: 0x1 idle, 0x2 transmit, 0x4 receive, 0x8 acknowledge;
  - bit 0 is the acknowledge mode: 1 for automatic, 0 for interrupt;
  - all other bits read 0, and writes to them have no effect.
- R5: A mode write always stores bit 0. It replaces the state only when bits 7:4 of the written value are one-hot. Otherwise the state is kept.
- R6: `ack_in[m]` high at a clock edge, with slot m not idle and its mode bit 1, makes the slot idle after that edge.
- R7: `ack_in[m]` high at a clock edge, with slot m not idle and its mode bit 0, makes the slot state acknowledge. The slot stays there until a later write changes it.
- R8: `ack_in[m]` has no effect while slot m is idle.
- R9: If an acknowledge and a mode write to the same slot happen at the same edge, the acknowledge decides the new state, using the mode bit held before that edge. The written bit 0 is still stored.
- R10: Slot offsets 0x24 to 0x3C read zero. Writes to them change no slot state, mode bit or data word.
- R11: `slot_state[4m+3:4m]` and `slot_auto[m]` always equal slot m's state field and mode bit.
- R12: An acknowledge or a write for one slot leaves every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 1 | Access request, one cycle per access |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 11 | Byte address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with `ready` |
| ready | output | 1 | Access completed, one cycle after `sel` |
| ack_in | input | 32 | Remote acknowledge, one bit per slot |
| slot_state | output | 128 | One-hot state of each slot, 4 bits per slot |
| slot_auto | output | 32 | Acknowledge mode bit of each slot |

## Verification
Directed sequences cover each path of the slot lifecycle:
- an acknowledge in automatic mode and in interrupt mode, which show that the two modes diverge;
- an acknowledge on an idle slot;
- an acknowledge that collides with a mode write, which separates the old mode bit from the new one;
- a state write that is not one-hot, which separates the state update from the mode-bit update.

Address patterns hit the first and last data words, the top slot and the unused gap of a slot, which expose decoding off by one word or one slot. A long random mix of reads, writes anywhere in the map and sparse multi-slot acknowledges is then compared against a reference model. That mix catches crosstalk between slots and fields.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'h1,
    ST_TX   = 4'h2,
    ST_RX   = 4'h4,
    ST_ACK  = 4'h8
  } mbx_state_e;

  localparam int unsigned STATE_LSB = 4;
  localparam int unsigned STATE_W   = 4;
  localparam int unsigned AUTO_BIT  = 0;

endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec #(
  parameter int unsigned NSLOT = 32,
  parameter int unsigned NWORD = 8,
  parameter int unsigned SW    = 5,
  parameter int unsigned OFFB  = 6,
  parameter int unsigned WW    = 3,
  parameter int unsigned AW    = SW + OFFB
) (
  input  logic [AW-1:0] addr,
  output logic [SW-1:0] slot_idx,
  output logic [WW-1:0] word_idx,
  output logic          is_mode,
  output logic          is_data
);

  logic [OFFB-3:0] off;
  logic [OFFB-3:0] off_m1;
  logic            slot_ok;
  logic            unused_lo;

  assign unused_lo = ^addr[1:0];
  assign slot_idx  = addr[AW-1:OFFB];
  assign off       = addr[OFFB-1:2];
  assign off_m1    = off - 1'b1;

  always_comb begin
    slot_ok  = (32'(slot_idx) < NSLOT);
    is_mode  = slot_ok && (off == '0);
    is_data  = slot_ok && (off != '0) && (32'(off) <= NWORD);
    word_idx = off_m1[WW-1:0];
  end

endmodule

// File: rtl/mbx_slot_fsm.sv
module mbx_slot_fsm
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_mode,
  input  logic [3:0] wr_state,
  input  logic       wr_auto,
  input  logic       ack_in,
  output logic [3:0] state,
  output logic       auto_ack
);

  mbx_state_e st_q, st_nx;
  logic       auto_q, auto_nx;
  logic       st_en;

  always_comb begin
    st_nx   = st_q;
    auto_nx = auto_q;
    if (wr_mode) begin
      auto_nx = wr_auto;
      if ($onehot(wr_state)) st_nx = mbx_state_e'(wr_state);
    end
    if (ack_in && (st_q != ST_IDLE)) begin
      st_nx = auto_q ? ST_IDLE : ST_ACK;
    end
    st_en = wr_mode || ack_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      auto_q <= 1'b0;
    end else if (st_en) begin
      st_q   <= st_nx;
      auto_q <= auto_nx;
    end
  end

  assign state    = st_q;
  assign auto_ack = auto_q;

endmodule

// File: rtl/mbx_data_store.sv
module mbx_data_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 32,
  parameter int unsigned IW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[idx] <= wdata;
    end
  end

  assign rdata = mem_q[idx];

endmodule

// File: rtl/mbx_slot_bank.sv
module mbx_slot_bank
  import mbx_pkg::*;
#(
  parameter int unsigned NSLOT = 32,
  parameter int unsigned NWORD = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int unsigned OFFB = $clog2((NWORD + 1) * 4),
  localparam int unsigned AW   = SW + OFFB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rd_data,
  output logic               ready,
  input  logic [NSLOT-1:0]   ack_in,
  output logic [NSLOT*4-1:0] slot_state,
  output logic [NSLOT-1:0]   slot_auto
);

  localparam int unsigned WW    = (NWORD > 1) ? $clog2(NWORD) : 1;
  localparam int unsigned DEPTH = NSLOT * NWORD;
  localparam int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s0, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  // address decode
  logic [SW-1:0] slot_idx;
  logic [WW-1:0] word_idx;
  logic          is_mode, is_data;

  mbx_addr_dec #(
    .NSLOT(NSLOT), .NWORD(NWORD), .SW(SW), .OFFB(OFFB), .WW(WW), .AW(AW)
  ) u_dec (
    .addr    (addr),
    .slot_idx(slot_idx),
    .word_idx(word_idx),
    .is_mode (is_mode),
    .is_data (is_data)
  );

  logic wr_acc, rd_acc;
  assign wr_acc = sel && wr_en;
  assign rd_acc = sel && !wr_en;

  // per-slot mode/state
  logic [3:0] st_arr   [NSLOT];
  logic       auto_arr [NSLOT];

  for (genvar g = 0; g < int'(NSLOT); g++) begin : g_slot
    logic wr_mode_g;
    assign wr_mode_g = wr_acc && is_mode && (32'(slot_idx) == g);

    mbx_slot_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_mode (wr_mode_g),
      .wr_state(wdata[STATE_LSB +: STATE_W]),
      .wr_auto (wdata[AUTO_BIT]),
      .ack_in  (ack_in[g]),
      .state   (st_arr[g]),
      .auto_ack(auto_arr[g])
    );

    assign slot_state[g*4 +: 4] = st_arr[g];
    assign slot_auto[g]         = auto_arr[g];
  end

  // payload storage
  logic [IW-1:0] mem_idx;
  logic [DW-1:0] mem_rdata;

  assign mem_idx = IW'(slot_idx) * IW'(NWORD) + IW'(word_idx);

  mbx_data_store #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_store (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .we   (wr_acc && is_data),
    .idx  (mem_idx),
    .wdata(wdata),
    .rdata(mem_rdata)
  );

  // read path and response
  logic [DW-1:0] rd_nx, rd_q;
  logic          rdy_q;

  always_comb begin
    rd_nx = '0;
    if (rd_acc) begin
      if (is_mode) begin
        rd_nx[STATE_LSB +: STATE_W] = st_arr[slot_idx];
        rd_nx[AUTO_BIT]             = auto_arr[slot_idx];
      end else if (is_data) begin
        rd_nx = mem_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q  <= '0;
      rdy_q <= 1'b0;
    end else begin
      rd_q  <= rd_nx;
      rdy_q <= sel;
    end
  end

  assign rd_data = rd_q;
  assign ready   = rdy_q;

endmodule

// File: rtl/mbx_slot_bank_chk.sv
module mbx_slot_bank_chk #(
  parameter int unsigned NSLOT = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned OFFB  = 6,
  parameter int unsigned AW    = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sel,
  input logic               wr_en,
  input logic [AW-1:0]      addr,
  input logic [DW-1:0]      rd_data,
  input logic               ready,
  input logic [NSLOT-1:0]   ack_in,
  input logic [NSLOT*4-1:0] slot_state,
  input logic [NSLOT-1:0]   slot_auto
);

  logic mode_rd;
  assign mode_rd = sel && !wr_en && (addr[OFFB-1:2] == '0);

  AST_READY_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> ready); // R3
  AST_NO_SPURIOUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !ready); // R3
  AST_MODE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(mode_rd)) |-> (rd_data[DW-1:8] == '0 && rd_data[3:1] == 3'b000)); // R4

  for (genvar g = 0; g < int'(NSLOT); g++) begin : g_chk
    logic [3:0] st;
    logic       wr_here;
    assign st      = slot_state[g*4 +: 4];
    assign wr_here = sel && wr_en && (32'(addr[AW-1:OFFB]) == g) && (addr[OFFB-1:2] == '0);

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(st)); // R4
    AST_AUTO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_in[g] && st != 4'h1 && slot_auto[g]) |=> (slot_state[g*4 +: 4] == 4'h1)); // R6
    AST_IRQ_ACK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_in[g] && st != 4'h1 && !slot_auto[g]) |=> (slot_state[g*4 +: 4] == 4'h8)); // R7
    AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_in[g] && st == 4'h1 && !wr_here) |=> (slot_state[g*4 +: 4] == 4'h1)); // R8
  end

endmodule

bind mbx_slot_bank mbx_slot_bank_chk #(
  .NSLOT(NSLOT), .DW(DW), .OFFB(OFFB), .AW(AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sel       (sel),
  .wr_en     (wr_en),
  .addr      (addr),
  .rd_data   (rd_data),
  .ready     (ready),
  .ack_in    (ack_in),
  .slot_state(slot_state),
  .slot_auto (slot_auto)
);

// File: tb/sim_mbx_slot_bank.sv
`timescale 1ns/1ps
module sim_mbx_slot_bank;

  localparam int NS = 32;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel, wr_en;
  logic [10:0]   addr;
  logic [31:0]   wdata, rd_data;
  logic          ready;
  logic [NS-1:0] ack_in;
  logic [NS*4-1:0] slot_state;
  logic [NS-1:0] slot_auto;

  always #2 clk = ~clk;

  mbx_slot_bank u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .ready(ready), .ack_in(ack_in),
    .slot_state(slot_state), .slot_auto(slot_auto)
  );

  int n_chk = 0;
  int n_err = 0;

  logic [3:0]  m_st   [NS];
  logic        m_auto [NS];
  logic [31:0] m_data [NS*NW];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_onehot4(input logic [3:0] v);
    return (v == 4'h1) || (v == 4'h2) || (v == 4'h4) || (v == 4'h8);
  endfunction

  function automatic logic [31:0] exp_read(input logic [10:0] a);
    int s = int'(a[10:6]);
    int o = int'(a[5:2]);
    logic [31:0] r = '0;
    if (o == 0) begin
      r[7:4] = m_st[s];
      r[0]   = m_auto[s];
    end else if (o <= NW) begin
      r = m_data[s*NW + o - 1];
    end
    return r;
  endfunction

  function automatic logic [10:0] mk_addr(input int s, input int o);
    return {5'(s), 4'(o), 2'b00};
  endfunction

  // one bus cycle plus acknowledge mask; model updated per requirements
  task automatic cyc(input logic s_i, input logic w_i, input logic [10:0] a,
                     input logic [31:0] d, input logic [NS-1:0] ak, input string tag);
    logic [31:0] exp_rd;
    logic [3:0]  pre_st [NS];
    logic        pre_au [NS];
    int sl, of;
    @(negedge clk);
    sel = s_i; wr_en = w_i; addr = a; wdata = d; ack_in = ak;
    for (int i = 0; i < NS; i++) begin pre_st[i] = m_st[i]; pre_au[i] = m_auto[i]; end
    exp_rd = (s_i && !w_i) ? exp_read(a) : 32'h0;
    sl = int'(a[10:6]); of = int'(a[5:2]);
    if (s_i && w_i) begin
      if (of == 0) begin
        m_auto[sl] = d[0];
        if (is_onehot4(d[7:4])) m_st[sl] = d[7:4];
      end else if (of <= NW) begin
        m_data[sl*NW + of - 1] = d;
      end
    end
    for (int i = 0; i < NS; i++)
      if (ak[i] && pre_st[i] != 4'h1) m_st[i] = pre_au[i] ? 4'h1 : 4'h8;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0; ack_in = '0;
    chk({"R3 ready ", tag}, 32'(ready), 32'(s_i));
    chk({"rd_data ", tag}, rd_data, exp_rd);
    for (int i = 0; i < NS; i++) begin
      chk({"R11 state ", tag}, 32'(slot_state[i*4 +: 4]), 32'(m_st[i]));
      chk({"R11 auto ", tag}, 32'(slot_auto[i]), 32'(m_auto[i]));
    end
  endtask

  task automatic wr(input int s, input int o, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, mk_addr(s, o), d, '0, tag);
  endtask
  task automatic rd(input int s, input int o, input string tag);
    cyc(1'b1, 1'b0, mk_addr(s, o), 32'h0, '0, tag);
  endtask
  task automatic ack(input logic [NS-1:0] m, input string tag);
    cyc(1'b0, 1'b0, 11'h0, 32'h0, m, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    sel = 0; wr_en = 0; addr = '0; wdata = '0; ack_in = '0;
    for (int i = 0; i < NS; i++) begin m_st[i] = 4'h1; m_auto[i] = 1'b0; end
    for (int i = 0; i < NS*NW; i++) m_data[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ready", 32'(ready), 0);
    chk("R1 rd_data", rd_data, 0);
    for (int i = 0; i < NS; i++) chk("R1 state", 32'(slot_state[i*4 +: 4]), 32'h1);
    chk("R1 auto", 32'(slot_auto), 0);
    rd(5, 0, "R1 mode");
    rd(5, 3, "R1 data");

    // R2 map corners
    wr(3, 1, 32'hA5A5_0001, "R2");
    wr(3, 8, 32'hA5A5_0008, "R2");
    wr(31, 8, 32'hDEAD_BEEF, "R2");
    rd(3, 1, "R2 first word");
    rd(3, 8, "R2 last word");
    rd(31, 8, "R2 top slot");
    cyc(1'b1, 1'b0, mk_addr(3, 8) | 11'h3, 32'h0, '0, "R2 low bits ignored");
    rd(4, 1, "R12 neighbour data");

    // R5 non-one-hot state kept, bit 0 stored
    wr(2, 0, 32'h0000_00F1, "R5");
    rd(2, 0, "R5 mode");
    // R4 reserved bits
    wr(2, 0, 32'hFFFF_FF2F, "R4");
    rd(2, 0, "R4 reserved zero");
    // R6 automatic acknowledge
    ack(32'h1 << 2, "R6 auto ack");
    rd(2, 0, "R6 mode");
    // R7 interrupt acknowledge
    wr(4, 0, 32'h0000_0040, "R7");
    ack(32'h1 << 4, "R7 irq ack");
    rd(4, 0, "R7 mode");
    ack(32'h1 << 4, "R7 hold");
    wr(4, 0, 32'h0000_0010, "R7 sw idle");
    // R8 idle ignores acknowledge
    ack(32'h1 << 6, "R8 idle ack");
    rd(6, 0, "R8 mode");
    // R9 collision
    wr(7, 0, 32'h0000_0021, "R9");
    cyc(1'b1, 1'b1, mk_addr(7, 0), 32'h0000_0040, 32'h1 << 7, "R9 collide");
    rd(7, 0, "R9 mode");
    // R10 unmapped offsets
    wr(1, 9, 32'h1234_5678, "R10");
    wr(1, 15, 32'h8765_4321, "R10");
    rd(1, 9, "R10 read");
    rd(1, 15, "R10 read");
    rd(1, 8, "R10 neighbour");
    // R12 independence
    wr(8, 0, 32'h0000_0020, "R12");
    wr(9, 0, 32'h0000_0020, "R12");
    ack(32'h1 << 8, "R12 single ack");
    rd(9, 0, "R12 other slot");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 3);
      int s  = $urandom_range(0, NS-1);
      int o  = $urandom_range(0, 15);
      logic [31:0] d = $urandom;
      if (o == 0 && $urandom_range(0, 1) == 1) d[7:4] = 4'h1 << $urandom_range(0, 3);
      case (op)
        0: cyc(1'b1, 1'b1, mk_addr(s, o), d, '0, "R2 R4 rand wr");
        1: cyc(1'b1, 1'b0, mk_addr(s, o), 32'h0, '0, "R2 R10 rand rd");
        2: cyc(1'b0, 1'b0, 11'h0, 32'h0, NS'($urandom) & NS'($urandom) & NS'($urandom), "R12 rand ack");
        default: cyc(1'b1, 1'b1, mk_addr(s, 0), d, NS'($urandom) & NS'($urandom), "R9 rand mix");
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule